// File: doc/BRIEF.md
# USB Host Token Launch Controller

This block decides what happens to a token request that software places for the host side of a USB controller. A request can be launched on the bus, dropped because it arrived too close to the end of the frame, or reissued after a NAK or an error while a programmable retry window is still open. When the transaction finally succeeds or gives up, the block reports one completion event.

The same unit also runs the bus-reset sequence. A request to reset the bus drives the reset line for a fixed number of clock cycles. The line then drops by itself and an end-of-reset event is raised. A reset request is refused while the controller is soft-reset, while the bus is suspended, or while a token is in flight. While the bus reset runs, writes to the control settings are frozen.

Packet encoding and the line drivers belong to neighbouring blocks. The enables for cancelling and retrying are held in a small control register that the block writes from a control-write strobe.

Top module: `tok_launch_ctrl`

## Requirements
- R1: With cancel enabled, a token written while `eof_win_i` is 1 is not launched. Instead `cancel_o` pulses high for one cycle, one cycle after the write.
- R2: With cancel disabled, or with `eof_win_i` at 0, a token write with a nonzero type gives a one-cycle `launch_o` pulse one cycle after the write. `launch_type_o` equals the written type and `busy_o` rises.
- R3: A token write whose 3-bit type is 000 produces no launch, no cancel and no busy.
- R4: With retry enabled, a NAK or an error arriving while the retry timer is below `retry_limit_i` relaunches the same type one cycle later, and `busy_o` stays 1. The timer starts at 0 on the first launch and counts the cycles spent busy.
- R5: A NAK or an error that cannot be retried pulses `done_o` with `done_ok_o` = 0 and clears `busy_o`. This applies when retry is disabled or when the timer has reached the limit.
- R6: An ACK pulses `done_o` once with `done_ok_o` = 1 and clears `busy_o` in the same cycle.
- R7: A control write with the bus-reset bit at 1 sets `busrst_o` for exactly RST_CYCLES cycles. `busrst_o` then drops to 0, and `busrst_end_o` pulses for one cycle in the cycle that follows the last high cycle.
- R8: A control write with the bus-reset bit at 0 does not start a bus reset.
- R9: A bus-reset request is ignored while `soft_rst_i` is 1, while `suspend_i` is 1, or while `busy_o` is 1.
- R10: While `busrst_o` is 1, control writes leave `cfg_cancel_o` and `cfg_retry_o` unchanged.
- R11: A token write is ignored while `busy_o` or `busrst_o` is 1.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | Controller soft reset is active |
| suspend_i | input | 1 | Bus is suspended |
| eof_win_i | input | 1 | Frame position is inside the end-of-frame window |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_cancel_i | input | 1 | Cancel-enable value to write |
| ctl_retry_i | input | 1 | Retry-enable value to write |
| ctl_busrst_i | input | 1 | Bus-reset request bit to write |
| retry_limit_i | input | TMR_W | Retry window length in cycles |
| tok_wr_i | input | 1 | Token request write strobe |
| tok_type_i | input | 3 | Token type code, 000 means none |
| res_ack_i | input | 1 | Transaction ended with ACK |
| res_nak_i | input | 1 | Transaction ended with NAK |
| res_err_i | input | 1 | Transaction ended with an error |
| cfg_cancel_o | output | 1 | Stored cancel enable |
| cfg_retry_o | output | 1 | Stored retry enable |
| launch_o | output | 1 | One-cycle token launch strobe |
| launch_type_o | output | 3 | Type of the token being launched |
| busy_o | output | 1 | A token is in flight |
| cancel_o | output | 1 | Token cancelled event |
| done_o | output | 1 | Token completion event |
| done_ok_o | output | 1 | Last completion was an ACK |
| busrst_o | output | 1 | Bus reset is being driven |
| busrst_end_o | output | 1 | Bus reset finished event |

## Verification
A corrupted token state shows at the ports one cycle after the next outcome pulse. It appears as a missing or extra `launch_o`, as a `done_o` without a preceding launch, or as `busy_o` stuck after completion. A wrong retry timer shows as a relaunch where a final failure is expected, or the other way round, and only at the first NAK after the window edge. A bus-reset counter fault shows as `busrst_o` staying high for the wrong number of cycles. A gating fault shows as a reset that starts, or a configuration bit that changes, in the cycle after a request that should have been refused.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef logic [2:0] tok_t;

    localparam tok_t TOK_NONE = 3'b000;

    typedef enum logic [0:0] {
        TS_IDLE = 1'b0,
        TS_WAIT = 1'b1
    } tok_state_e;

    typedef struct packed {
        logic cancel_en;
        logic retry_en;
    } ctl_cfg_t;

    function automatic logic tok_valid(input tok_t t);
        return t != TOK_NONE;
    endfunction

endpackage

// File: rtl/tlc_tok_fsm.sv
module tlc_tok_fsm
    import tlc_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_cfg_t         cfg,
    input  logic             hold,
    input  logic             eof_win,
    input  logic             tok_wr,
    input  tok_t             tok_type,
    input  logic [TMR_W-1:0] limit,
    input  logic             ack,
    input  logic             nak,
    input  logic             err,
    output logic             launch,
    output tok_t             launch_type,
    output logic             busy,
    output logic             cancel,
    output logic             done,
    output logic             done_ok
);

    localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

    tok_state_e       state;
    tok_t             cur;
    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TS_IDLE;
            cur     <= TOK_NONE;
            tmr     <= '0;
            launch  <= 1'b0;
            cancel  <= 1'b0;
            done    <= 1'b0;
            done_ok <= 1'b0;
        end else begin
            launch <= 1'b0;
            cancel <= 1'b0;
            done   <= 1'b0;
            unique case (state)
                TS_IDLE: begin
                    if (tok_wr && tok_valid(tok_type) && !hold) begin
                        if (cfg.cancel_en && eof_win) begin
                            cancel <= 1'b1;
                        end else begin
                            launch <= 1'b1;
                            cur    <= tok_type;
                            tmr    <= '0;
                            state  <= TS_WAIT;
                        end
                    end
                end
                TS_WAIT: begin
                    if (tmr != TMR_MAX) tmr <= tmr + 1'b1;
                    if (ack) begin
                        done    <= 1'b1;
                        done_ok <= 1'b1;
                        state   <= TS_IDLE;
                    end else if (nak || err) begin
                        if (cfg.retry_en && (tmr < limit)) begin
                            launch <= 1'b1;
                        end else begin
                            done    <= 1'b1;
                            done_ok <= 1'b0;
                            state   <= TS_IDLE;
                        end
                    end
                end
                default: state <= TS_IDLE;
            endcase
        end
    end

    assign busy        = (state == TS_WAIT);
    assign launch_type = cur;

    assert_launch_cancel_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(launch && cancel));

    assert_done_clears_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state == TS_WAIT));

    assert_no_launch_when_held_R11: assert property (@(posedge clk) disable iff (rst)
        (hold && state == TS_IDLE) |=> !launch);

endmodule

// File: rtl/tlc_busrst.sv
module tlc_busrst #(
    parameter int RST_CYCLES = 480000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic end_pulse
);

    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            end_pulse <= 1'b0;
            cnt       <= '0;
        end else begin
            end_pulse <= 1'b0;
            if (active) begin
                if (cnt == LAST) begin
                    active    <= 1'b0;
                    end_pulse <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (start) begin
                active <= 1'b1;
                cnt    <= '0;
            end
        end
    end

    assert_end_follows_drive_R7: assert property (@(posedge clk) disable iff (rst)
        end_pulse |-> (!active && $past(active)));

    assert_end_single_R7: assert property (@(posedge clk) disable iff (rst)
        end_pulse |=> !end_pulse);

endmodule

// File: rtl/tok_launch_ctrl.sv
module tok_launch_ctrl
    import tlc_pkg::*;
#(
    parameter int TMR_W      = 16,
    parameter int RST_CYCLES = 480000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst_i,
    input  logic             suspend_i,
    input  logic             eof_win_i,
    input  logic             ctl_wr_i,
    input  logic             ctl_cancel_i,
    input  logic             ctl_retry_i,
    input  logic             ctl_busrst_i,
    input  logic [TMR_W-1:0] retry_limit_i,
    input  logic             tok_wr_i,
    input  logic [2:0]       tok_type_i,
    input  logic             res_ack_i,
    input  logic             res_nak_i,
    input  logic             res_err_i,
    output logic             cfg_cancel_o,
    output logic             cfg_retry_o,
    output logic             launch_o,
    output logic [2:0]       launch_type_o,
    output logic             busy_o,
    output logic             cancel_o,
    output logic             done_o,
    output logic             done_ok_o,
    output logic             busrst_o,
    output logic             busrst_end_o
);

    ctl_cfg_t cfg;
    logic     rst_start;
    logic     busy_w;
    logic     brst_w;

    always_ff @(posedge clk) begin
        if (rst)                       cfg <= '0;
        else if (ctl_wr_i && !brst_w)  cfg <= '{cancel_en: ctl_cancel_i, retry_en: ctl_retry_i};
    end

    assign rst_start = ctl_wr_i && ctl_busrst_i && !brst_w && !busy_w
                       && !soft_rst_i && !suspend_i;

    tlc_tok_fsm #(.TMR_W(TMR_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .hold        (brst_w || rst_start),
        .eof_win     (eof_win_i),
        .tok_wr      (tok_wr_i),
        .tok_type    (tok_type_i),
        .limit       (retry_limit_i),
        .ack         (res_ack_i),
        .nak         (res_nak_i),
        .err         (res_err_i),
        .launch      (launch_o),
        .launch_type (launch_type_o),
        .busy        (busy_w),
        .cancel      (cancel_o),
        .done        (done_o),
        .done_ok     (done_ok_o)
    );

    tlc_busrst #(.RST_CYCLES(RST_CYCLES)) u_brst (
        .clk       (clk),
        .rst       (rst),
        .start     (rst_start),
        .active    (brst_w),
        .end_pulse (busrst_end_o)
    );

    assign busy_o       = busy_w;
    assign busrst_o     = brst_w;
    assign cfg_cancel_o = cfg.cancel_en;
    assign cfg_retry_o  = cfg.retry_en;

    assert_busrst_gated_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busrst_o) |-> $past(!suspend_i && !soft_rst_i && !busy_o));

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        $past(busrst_o) |-> $stable(cfg));

    assert_busy_excl_busrst_R11: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && busrst_o));

endmodule

// File: tb/sim_tok_launch_ctrl.sv
module sim_tok_launch_ctrl;

    localparam int TMR_W  = 8;
    localparam int RST_CY = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic soft_rst_i = 0, suspend_i = 0, eof_win_i = 0;
    logic ctl_wr_i = 0, ctl_cancel_i = 0, ctl_retry_i = 0, ctl_busrst_i = 0;
    logic [TMR_W-1:0] retry_limit_i = 8'd50;
    logic tok_wr_i = 0;
    logic [2:0] tok_type_i = 3'd0;
    logic res_ack_i = 0, res_nak_i = 0, res_err_i = 0;
    logic cfg_cancel_o, cfg_retry_o, launch_o, busy_o, cancel_o;
    logic done_o, done_ok_o, busrst_o, busrst_end_o;
    logic [2:0] launch_type_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    tok_launch_ctrl #(.TMR_W(TMR_W), .RST_CYCLES(RST_CY)) u0 (
        .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .suspend_i(suspend_i),
        .eof_win_i(eof_win_i), .ctl_wr_i(ctl_wr_i), .ctl_cancel_i(ctl_cancel_i),
        .ctl_retry_i(ctl_retry_i), .ctl_busrst_i(ctl_busrst_i),
        .retry_limit_i(retry_limit_i), .tok_wr_i(tok_wr_i), .tok_type_i(tok_type_i),
        .res_ack_i(res_ack_i), .res_nak_i(res_nak_i), .res_err_i(res_err_i),
        .cfg_cancel_o(cfg_cancel_o), .cfg_retry_o(cfg_retry_o), .launch_o(launch_o),
        .launch_type_o(launch_type_o), .busy_o(busy_o), .cancel_o(cancel_o),
        .done_o(done_o), .done_ok_o(done_ok_o), .busrst_o(busrst_o),
        .busrst_end_o(busrst_end_o)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic c, input logic r, input logic b);
        ctl_wr_i = 1; ctl_cancel_i = c; ctl_retry_i = r; ctl_busrst_i = b;
        tick();
        ctl_wr_i = 0; ctl_busrst_i = 0;
    endtask

    task automatic tok_write(input logic [2:0] t);
        tok_wr_i = 1; tok_type_i = t;
        tick();
        tok_wr_i = 0; tok_type_i = 3'd0;
    endtask

    task automatic outcome(input logic a, input logic n, input logic e);
        res_ack_i = a; res_nak_i = n; res_err_i = e;
        tick();
        res_ack_i = 0; res_nak_i = 0; res_err_i = 0;
    endtask

    // fields: cancel_en, eof, type[2:0], exp_launch, exp_cancel
    localparam logic [6:0] VEC [7] = '{
        {1'b1, 1'b1, 3'd1, 1'b0, 1'b1},
        {1'b1, 1'b0, 3'd2, 1'b1, 1'b0},
        {1'b0, 1'b1, 3'd3, 1'b1, 1'b0},
        {1'b0, 1'b0, 3'd5, 1'b1, 1'b0},
        {1'b1, 1'b1, 3'd0, 1'b0, 1'b0},
        {1'b0, 1'b0, 3'd0, 1'b0, 1'b0},
        {1'b1, 1'b1, 3'd7, 1'b0, 1'b1}
    };

    initial begin
        tick(); tick();
        rst = 0;
        tick();
        // R12 reset state
        chk("R12 busy", busy_o, 0);
        chk("R12 launch", launch_o, 0);
        chk("R12 busrst", busrst_o, 0);
        chk("R12 cfg", {cfg_cancel_o, cfg_retry_o}, 0);
        chk("R12 done", done_o, 0);

        // table walk: R1, R2, R3, R6
        for (int i = 0; i < 7; i++) begin
            logic [6:0] v;
            v = VEC[i];
            ctl_write(v[6], 1'b0, 1'b0);
            eof_win_i = v[5];
            tok_write(v[4:2]);
            eof_win_i = 0;
            chk("R1/R2/R3 launch", launch_o, v[1]);
            chk("R1 cancel", cancel_o, v[0]);
            chk("R2/R3 busy", busy_o, v[1]);
            if (v[1]) begin
                chk("R2 type", launch_type_o, v[4:2]);
                tick();
                chk("R2 launch single", launch_o, 0);
                outcome(1, 0, 0);
                chk("R6 done", done_o, 1);
                chk("R6 ok", done_ok_o, 1);
                chk("R6 busy", busy_o, 0);
                tick();
                chk("R6 done single", done_o, 0);
            end else begin
                tick();
                chk("R1 cancel single", cancel_o, 0);
                chk("R3 idle", busy_o, 0);
            end
        end

        // R4 retry within window
        retry_limit_i = 8'd50;
        ctl_write(0, 1, 0);
        tok_write(3'd4);
        outcome(0, 1, 0);
        chk("R4 nak relaunch", launch_o, 1);
        chk("R4 type", launch_type_o, 4);
        chk("R4 busy", busy_o, 1);
        outcome(0, 0, 1);
        chk("R4 err relaunch", launch_o, 1);
        chk("R4 no done", done_o, 0);
        outcome(1, 0, 0);
        chk("R6 done after retry", done_ok_o, 1);

        // R5 retry disabled
        ctl_write(0, 0, 0);
        tok_write(3'd6);
        outcome(0, 1, 0);
        chk("R5 no relaunch", launch_o, 0);
        chk("R5 done", done_o, 1);
        chk("R5 fail", done_ok_o, 0);
        chk("R5 busy", busy_o, 0);

        // R5 window exhausted
        retry_limit_i = 8'd3;
        ctl_write(0, 1, 0);
        tok_write(3'd1);
        for (int k = 0; k < 6; k++) tick();
        outcome(0, 0, 1);
        chk("R5 window launch", launch_o, 0);
        chk("R5 window done", done_o, 1);
        chk("R5 window fail", done_ok_o, 0);

        // R11 token write while busy
        retry_limit_i = 8'd50;
        tok_write(3'd2);
        tok_write(3'd5);
        chk("R11 busy launch", launch_o, 0);
        chk("R11 type kept", launch_type_o, 2);
        outcome(1, 0, 0);

        // R9 busrst refused while busy
        tok_write(3'd3);
        ctl_write(0, 1, 1);
        chk("R9 busy gate", busrst_o, 0);
        outcome(1, 0, 0);

        // R8 write 0
        ctl_write(0, 1, 0);
        tick();
        chk("R8 no busrst", busrst_o, 0);

        // R9 suspend / soft reset
        suspend_i = 1;
        ctl_write(0, 1, 1);
        chk("R9 suspend gate", busrst_o, 0);
        suspend_i = 0;
        soft_rst_i = 1;
        ctl_write(0, 1, 1);
        chk("R9 soft gate", busrst_o, 0);
        soft_rst_i = 0;

        // R7 bus reset duration, R10, R11 during reset
        ctl_write(0, 0, 1);
        chk("R7 start", busrst_o, 1);
        for (int i = 1; i < RST_CY; i++) begin
            if (i == 2) begin ctl_wr_i = 1; ctl_cancel_i = 1; ctl_retry_i = 1; end
            if (i == 4) begin tok_wr_i = 1; tok_type_i = 3'd3; end
            tick();
            ctl_wr_i = 0; tok_wr_i = 0; tok_type_i = 3'd0;
            chk("R7 held", busrst_o, 1);
            chk("R7 no early end", busrst_end_o, 0);
            chk("R11 no launch in reset", launch_o, 0);
        end
        tick();
        chk("R7 drop", busrst_o, 0);
        chk("R7 end", busrst_end_o, 1);
        chk("R10 cancel frozen", cfg_cancel_o, 0);
        chk("R10 retry frozen", cfg_retry_o, 0);
        tick();
        chk("R7 end single", busrst_end_o, 0);

        summary();
        $finish;
    end

endmodule